// File: doc/BRIEF.md
# Dual-Clock Burst-Capable Shared Word Memory

This block is a word-wide memory with two fully independent bus-slave ports. Each port has its own clock and its own synchronous reset. Each port follows the Wishbone B3 handshake: the master raises cycle and strobe, and the slave answers with an acknowledge. A port accepts classic single transfers and registered-feedback bursts. For a burst, the cycle type and burst type inputs tell the port which word comes next. The port can then fetch that word ahead of time and acknowledge one beat on every clock.

Both ports read and write the same storage, so a word written through one port can be read through the other. Collisions are not arbitrated: if the two ports write the same word in overlapping clocks, the result is undefined. Users keep the two ports on separate address ranges while they write.

Flow control works as follows. A master inserts a wait by dropping strobe while it keeps cycle high. A port never acknowledges in a clock where strobe or cycle is low. The master must hold address, data, select and write enable stable until it sees the acknowledge.

Top module: `wbram_dp`

## Requirements
- R1: While a port's reset is high, that port's acknowledge stays low, whatever its other inputs are.
- R2: A classic transfer (cycle type 3'b000) is acknowledged in the second clock after strobe rises. The acknowledge lasts exactly one clock and drops in the next clock, even if strobe stays high.
- R3: Select bit n enables writing of data bits [8n+7:8n]; deselected bytes keep their old contents. Writing 0xA1FFFFFF with select 4'b1000 over 0x00030004 leaves 0xA1030004.
- R4: In a burst, cycle type 3'b010 means another beat follows and 3'b111 marks the last beat. With burst type 2'b00 (linear), consecutive words are transferred. The first beat waits one clock, and every later beat is acknowledged in the clock it is presented.
- R5: Burst types 2'b01, 2'b10 and 2'b11 wrap within aligned blocks of 4, 8 and 16 words. Only the low 2, 3 or 4 word-address bits advance, modulo the block size. For example, a 4-beat wrap from word 0x42 returns words 0x42, 0x43, 0x40, 0x41.
- R6: If strobe drops mid-burst while cycle stays high, there is no acknowledge in that clock. When strobe returns, the burst resumes at the same beat, after one wait clock.
- R7: A first beat that carries cycle type 3'b111 is a single transfer, whatever the burst type. It gets one acknowledge, and the acknowledge drops in the next clock.
- R8: A word written through either port reads back through the other port.
- R9: While cycle is low, no acknowledge is given, even if strobe is high.
- R10: The two ports run concurrently on unrelated clocks (here port B runs twice as fast as port A). Traffic on disjoint address ranges does not interfere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_cyc | input | 1 | Port A bus cycle in progress |
| a_stb | input | 1 | Port A transfer request |
| a_we | input | 1 | Port A write enable |
| a_cti | input | 3 | Port A cycle type (000 classic, 010 more beats, 111 last) |
| a_bte | input | 2 | Port A burst type (00 linear, 01/10/11 wrap 4/8/16) |
| a_adr | input | 30 | Port A word address (byte address bits 31:2) |
| a_sel | input | DW/8 | Port A byte-lane select |
| a_wdat | input | DW | Port A write data |
| a_rdat | output | DW | Port A read data, valid with acknowledge |
| a_ack | output | 1 | Port A acknowledge |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_cyc | input | 1 | Port B bus cycle in progress |
| b_stb | input | 1 | Port B transfer request |
| b_we | input | 1 | Port B write enable |
| b_cti | input | 3 | Port B cycle type |
| b_bte | input | 2 | Port B burst type |
| b_adr | input | 30 | Port B word address |
| b_sel | input | DW/8 | Port B byte-lane select |
| b_wdat | input | DW | Port B write data |
| b_rdat | output | DW | Port B read data, valid with acknowledge |
| b_ack | output | 1 | Port B acknowledge |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Wrap point of each burst size.** A port that carried into the upper address bits would return the wrong word there.
- **Strobe-low stall in mid-burst.** A registered acknowledge that ignored strobe would complete a phantom beat and skip a word.
- **End-of-burst code on a first beat.** If this were treated as a burst, the acknowledge would stream on or the port would prefetch the wrong word.
- **Partial byte selects.** Wrong lane handling would clobber neighbouring bytes.
- **Concurrent traffic on both clocks, followed by cross-port reads.** These expose a shared store that loses one port's writes.

// File: rtl/wbram_pkg.sv
`timescale 1ns/1ps
package wbram_pkg;

  // cycle type codes
  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_LAST    = 3'b111;

  // burst type codes
  localparam logic [1:0] BTE_LINEAR = 2'b00;
  localparam logic [1:0] BTE_WRAP4  = 2'b01;
  localparam logic [1:0] BTE_WRAP8  = 2'b10;
  localparam logic [1:0] BTE_WRAP16 = 2'b11;

  // low-bit mask that advances inside a wrap block; zero for linear
  function automatic logic [3:0] wrap_low_mask(input logic [1:0] bte);
    case (bte)
      BTE_WRAP4:  return 4'h3;
      BTE_WRAP8:  return 4'h7;
      BTE_WRAP16: return 4'hF;
      default:    return 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/wbram_port_ctl.sv
`timescale 1ns/1ps
module wbram_port_ctl
  import wbram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [2:0]    cti,
  input  logic [1:0]    bte,
  input  logic [AW-1:0] adr,
  output logic          ack,
  output logic          wr_en,
  output logic [AW-1:0] mem_raddr,
  output logic [AW-1:0] mem_waddr
);

  logic          req;
  logic          ack_q;
  logic          more_beats;
  logic [AW-1:0] step_mask;
  logic [AW-1:0] adr_inc;
  logic [AW-1:0] adr_next;

  assign req        = cyc & stb;
  assign more_beats = (cti == CTI_INCR);
  // registered acknowledge is only shown while the request is still up
  assign ack        = ack_q & req;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= req & ~(ack & ~more_beats);
  end

  // predicted address of the following beat
  always_comb begin
    if (bte == BTE_LINEAR) step_mask = '1;
    else                   step_mask = {{(AW-4){1'b0}}, wrap_low_mask(bte)};
    adr_inc  = adr + AW'(1);
    adr_next = (adr & ~step_mask) | (adr_inc & step_mask);
  end

  assign mem_raddr = (ack && more_beats) ? adr_next : adr;
  assign mem_waddr = adr;
  assign wr_en     = ack & we;

  a_r2_classic_single_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && cti != CTI_INCR) |=> !ack);

  a_r4_burst_ack_streams: assert property (@(posedge clk) disable iff (rst)
    (ack && more_beats) |=> (ack || !(cyc && stb)));

  a_r5_wrap_in_block: assert property (@(posedge clk) disable iff (rst)
    (ack && more_beats && bte != BTE_LINEAR) |-> (mem_raddr[AW-1:4] == adr[AW-1:4]));

  a_r9_no_ack_without_cycle: assert property (@(posedge clk) disable iff (rst)
    !cyc |=> !ack_q);

endmodule

// File: rtl/wbram_bank.sv
`timescale 1ns/1ps
module wbram_bank #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW/8-1:0] sel,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  input  logic [DW-1:0]   peer_at_waddr,
  input  logic [DW-1:0]   peer_at_raddr,
  input  logic [AW-1:0]   look_w,
  input  logic [AW-1:0]   look_r,
  output logic [DW-1:0]   self_at_look_w,
  output logic [DW-1:0]   self_at_look_r,
  output logic [DW-1:0]   rdata
);

  localparam int DEPTH = 1 << AW;
  localparam int NB    = DW / 8;

  logic [DW-1:0] store [DEPTH];

  // this bank holds data XOR peer bank, so the sum of both is the word
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < NB; l++) begin
        if (sel[l]) store[waddr][l*8 +: 8] <= wdata[l*8 +: 8] ^ peer_at_waddr[l*8 +: 8];
      end
    end
    rdata <= store[raddr] ^ peer_at_raddr;
  end

  assign self_at_look_w = store[look_w];
  assign self_at_look_r = store[look_r];

  a_r3_unselected_lane_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel[0]) |=> (store[$past(waddr)][7:0] == $past(store[waddr][7:0])));

endmodule

// File: rtl/wbram_dp.sv
`timescale 1ns/1ps
module wbram_dp #(
  parameter int MEM_AW = 8,
  parameter int DW     = 32
) (
  input  logic            a_clk,
  input  logic            a_rst,
  input  logic            a_cyc,
  input  logic            a_stb,
  input  logic            a_we,
  input  logic [2:0]      a_cti,
  input  logic [1:0]      a_bte,
  input  logic [29:0]     a_adr,
  input  logic [DW/8-1:0] a_sel,
  input  logic [DW-1:0]   a_wdat,
  output logic [DW-1:0]   a_rdat,
  output logic            a_ack,
  input  logic            b_clk,
  input  logic            b_rst,
  input  logic            b_cyc,
  input  logic            b_stb,
  input  logic            b_we,
  input  logic [2:0]      b_cti,
  input  logic [1:0]      b_bte,
  input  logic [29:0]     b_adr,
  input  logic [DW/8-1:0] b_sel,
  input  logic [DW-1:0]   b_wdat,
  output logic [DW-1:0]   b_rdat,
  output logic            b_ack
);

  logic              a_wen, b_wen;
  logic [MEM_AW-1:0] a_raddr, a_waddr, b_raddr, b_waddr;
  logic [DW-1:0]     a_at_bw, a_at_br, b_at_aw, b_at_ar;
  logic              unused_adr_hi;

  assign unused_adr_hi = ^{a_adr[29:MEM_AW], b_adr[29:MEM_AW]};

  wbram_port_ctl #(.AW(MEM_AW)) u_ctl_a (
    .clk(a_clk), .rst(a_rst), .cyc(a_cyc), .stb(a_stb), .we(a_we),
    .cti(a_cti), .bte(a_bte), .adr(a_adr[MEM_AW-1:0]),
    .ack(a_ack), .wr_en(a_wen), .mem_raddr(a_raddr), .mem_waddr(a_waddr)
  );

  wbram_port_ctl #(.AW(MEM_AW)) u_ctl_b (
    .clk(b_clk), .rst(b_rst), .cyc(b_cyc), .stb(b_stb), .we(b_we),
    .cti(b_cti), .bte(b_bte), .adr(b_adr[MEM_AW-1:0]),
    .ack(b_ack), .wr_en(b_wen), .mem_raddr(b_raddr), .mem_waddr(b_waddr)
  );

  wbram_bank #(.AW(MEM_AW), .DW(DW)) u_bank_a (
    .clk(a_clk), .rst(a_rst), .wr_en(a_wen), .sel(a_sel),
    .waddr(a_waddr), .wdata(a_wdat), .raddr(a_raddr),
    .peer_at_waddr(b_at_aw), .peer_at_raddr(b_at_ar),
    .look_w(b_waddr), .look_r(b_raddr),
    .self_at_look_w(a_at_bw), .self_at_look_r(a_at_br),
    .rdata(a_rdat)
  );

  wbram_bank #(.AW(MEM_AW), .DW(DW)) u_bank_b (
    .clk(b_clk), .rst(b_rst), .wr_en(b_wen), .sel(b_sel),
    .waddr(b_waddr), .wdata(b_wdat), .raddr(b_raddr),
    .peer_at_waddr(a_at_bw), .peer_at_raddr(a_at_br),
    .look_w(a_waddr), .look_r(a_raddr),
    .self_at_look_w(b_at_aw), .self_at_look_r(b_at_ar),
    .rdata(b_rdat)
  );

endmodule

// File: tb/wbram_dp_tb.sv
`timescale 1ns/1ps
module wbram_dp_tb;

  localparam int CLK_A_PERIOD = 20;
  localparam int CLK_B_PERIOD = CLK_A_PERIOD / 2;
  localparam int WATCHDOG_NS  = 4_000_000;
  localparam logic [2:0] C_CLASSIC = 3'b000;
  localparam logic [2:0] C_INCR    = 3'b010;
  localparam logic [2:0] C_LAST    = 3'b111;

  logic        clk_a = 1'b0, clk_b = 1'b0;
  logic [1:0]  rst = 2'b11, cyc = 2'b00, stb = 2'b00, we = 2'b00, ack;
  logic [29:0] adr  [2];
  logic [3:0]  sel  [2];
  logic [31:0] wdat [2];
  logic [2:0]  cti  [2];
  logic [1:0]  bte  [2];
  logic [31:0] rdat [2];
  logic [31:0] model [256];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  wbram_dp u_dut (
    .a_clk(clk_a), .a_rst(rst[0]), .a_cyc(cyc[0]), .a_stb(stb[0]), .a_we(we[0]),
    .a_cti(cti[0]), .a_bte(bte[0]), .a_adr(adr[0]), .a_sel(sel[0]), .a_wdat(wdat[0]),
    .a_rdat(rdat[0]), .a_ack(ack[0]),
    .b_clk(clk_b), .b_rst(rst[1]), .b_cyc(cyc[1]), .b_stb(stb[1]), .b_we(we[1]),
    .b_cti(cti[1]), .b_bte(bte[1]), .b_adr(adr[1]), .b_sel(sel[1]), .b_wdat(wdat[1]),
    .b_rdat(rdat[1]), .b_ack(ack[1])
  );

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (s[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [29:0] next_addr(input logic [29:0] a, input logic [1:0] b);
    int n, off;
    if (b == 2'b00) return a + 30'd1;
    n   = 2 << b;               // 4, 8, 16
    off = int'(a % 30'(n));
    return a - 30'(off) + 30'((off + 1) % n);
  endfunction

  task automatic pos(input int p);
    if (p == 0) @(posedge clk_a); else @(posedge clk_b);
  endtask

  task automatic neg(input int p);
    if (p == 0) @(negedge clk_a); else @(negedge clk_b);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic beat(input int p, input logic w, input logic [29:0] a, input logic [3:0] s,
                      input logic [31:0] d, input logic [2:0] c, input logic [1:0] b,
                      output logic [31:0] rd, output int ncyc);
    pos(p); #1;
    cyc[p] = 1'b1; stb[p] = 1'b1; we[p] = w; adr[p] = a;
    sel[p] = s; wdat[p] = d; cti[p] = c; bte[p] = b;
    ncyc = 0;
    do begin neg(p); ncyc++; end while (ack[p] !== 1'b1 && ncyc < 40);
    rd = rdat[p];
  endtask

  task automatic idle(input int p);
    pos(p); #1;
    cyc[p] = 1'b0; stb[p] = 1'b0; we[p] = 1'b0;
  endtask

  // one classic transfer; checks latency, data and that ack drops next clock
  task automatic single(input int p, input logic w, input logic [29:0] a, input logic [3:0] s,
                        input logic [31:0] d, input string req);
    logic [31:0] rd; int nc;
    beat(p, w, a, s, d, C_CLASSIC, 2'b00, rd, nc);
    check(req, "classic ack latency", nc, 2);
    if (w) model[a[7:0]] = merge(model[a[7:0]], d, s);
    else   check(req, "classic read", rd, model[a[7:0]]);
    pos(p); neg(p);
    check("R2", "ack after classic", {31'b0, ack[p]}, 0);
    idle(p);
  endtask

  task automatic burst(input int p, input logic w, input logic [29:0] start, input logic [1:0] b,
                       input int n, input int stall_at, input string req);
    logic [29:0] a = start;
    logic [31:0] rd, d;
    int nc;
    for (int k = 0; k < n; k++) begin
      if (k == stall_at) begin
        pos(p); #1 stb[p] = 1'b0;
        neg(p);
        check("R6", "ack during stall", {31'b0, ack[p]}, 0);
      end
      d = $urandom;
      beat(p, w, a, 4'hF, d, (k == n-1) ? C_LAST : C_INCR, b, rd, nc);
      check(req, "beat ack latency", nc, (k == 0 || k == stall_at) ? 2 : 1);
      if (w) model[a[7:0]] = d;
      else   check(req, "burst read", rd, model[a[7:0]]);
      a = next_addr(a, b);
    end
    idle(p);
  endtask

  task automatic rand_port(input int p, input int base, input int ops);
    for (int i = 0; i < ops; i++) begin
      int kind = int'($urandom % 4);
      if (kind == 0)
        single(p, 1'b1, 30'(base + int'($urandom % 128)), 4'($urandom), $urandom, "R10");
      else if (kind == 1)
        single(p, 1'b0, 30'(base + int'($urandom % 128)), 4'hF, 0, "R10");
      else begin
        logic [1:0] b = 2'($urandom);
        int n  = (b == 0) ? 1 + int'($urandom % 6) : (2 << b);
        int st = (n > 1 && ($urandom % 3) == 0) ? 1 + int'($urandom % (n-1)) : -1;
        int s0 = (b == 0) ? base + int'($urandom % (128 - n)) : base + int'($urandom % 128);
        burst(p, kind == 2, 30'(s0), b, n, st, "R10");
      end
    end
  endtask

  initial begin
    logic [31:0] rd; int nc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      adr[i] = '0; sel[i] = '0; wdat[i] = '0; cti[i] = '0; bte[i] = '0;
    end
    for (int i = 0; i < 256; i++) model[i] = '0;
    // R1: request held during reset must not be acknowledged
    cyc = 2'b11; stb = 2'b11;
    repeat (4) @(negedge clk_a);
    check("R1", "port A ack in reset", {31'b0, ack[0]}, 0);
    check("R1", "port B ack in reset", {31'b0, ack[1]}, 0);
    cyc = 2'b00; stb = 2'b00;
    @(negedge clk_a);
    rst = 2'b00;
    @(negedge clk_a);
    check("R1", "port A ack after reset", {31'b0, ack[0]}, 0);

    // R4 R10: concurrent linear fill of each region
    fork
      burst(0, 1'b1, 30'd0,   2'b00, 128, -1, "R4");
      burst(1, 1'b1, 30'd128, 2'b00, 128, -1, "R4");
    join
    burst(0, 1'b0, 30'd5, 2'b00, 6, -1, "R4");

    // R3: byte lanes
    single(0, 1'b1, 30'h41, 4'hF, 32'h00030004, "R3");
    single(0, 1'b1, 30'h41, 4'b1000, 32'hA1FFFFFF, "R3");
    beat(0, 1'b0, 30'h41, 4'hF, 0, C_CLASSIC, 2'b00, rd, nc);
    check("R3", "merged word", rd, 32'hA1030004);
    idle(0);
    single(1, 1'b1, 30'd200, 4'b0101, 32'h11223344, "R3");
    single(1, 1'b0, 30'd200, 4'hF, 0, "R3");

    // R5: wrapping bursts of each size
    burst(0, 1'b1, 30'h40, 2'b00, 4, -1, "R5");
    burst(0, 1'b0, 30'h42, 2'b01, 4, -1, "R5");
    burst(1, 1'b0, 30'd157, 2'b10, 8, -1, "R5");
    burst(1, 1'b1, 30'd183, 2'b11, 16, -1, "R5");
    burst(1, 1'b0, 30'd176, 2'b00, 16, -1, "R5");

    // R6: strobe-low stalls
    burst(0, 1'b0, 30'h40, 2'b01, 4, 2, "R6");
    burst(1, 1'b1, 30'd140, 2'b00, 5, 3, "R6");
    burst(1, 1'b0, 30'd140, 2'b00, 5, 1, "R6");

    // R7: end code on the first beat with a wrap type
    beat(1, 1'b0, 30'd142, 4'hF, 0, C_LAST, 2'b01, rd, nc);
    check("R7", "single ack latency", nc, 2);
    check("R7", "single read", rd, model[142]);
    pos(1); neg(1);
    check("R7", "no second ack", {31'b0, ack[1]}, 0);
    idle(1);

    // R9: strobe without cycle
    for (int p = 0; p < 2; p++) begin
      pos(p); #1 cyc[p] = 1'b0; stb[p] = 1'b1;
      for (int k = 0; k < 3; k++) begin
        neg(p);
        check("R9", "ack without cycle", {31'b0, ack[p]}, 0);
      end
      idle(p);
    end

    // R10: concurrent random traffic on disjoint halves
    fork
      rand_port(0, 0, 150);
      rand_port(1, 128, 150);
    join

    // R8: cross-port reads
    for (int i = 0; i < 20; i++) begin
      single(0, 1'b0, 30'(128 + int'($urandom % 128)), 4'hF, 0, "R8");
      single(1, 1'b0, 30'($urandom % 128), 4'hF, 0, "R8");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule